// File: doc/BRIEF.md
# Boundary-Scan Cell Ring with Signature Compression and Pattern Generation

This block is the ring of test cells that sits between a bus transceiver's data pins and its functional core. Every cell has a shift stage, which forms a serial path from `tdi` to `tdo`, and an update stage, which holds a value that can be driven into the core or onto the output pins. An external test access port controller supplies decoded strobes for capture, shift, update and run-test/idle, plus a 2-bit operating code. Everything runs on `tck`.

Four operating modes exist. In sample mode the functional path is untouched: capture and shift read the pins without disturbing them. In the three test modes the functional path is cut off. In extest the update stage drives the core inputs and the output pins. In signature mode the input half of the shift stage compresses successive input-pin words on each run-idle clock. In pattern mode the output half of the shift stage becomes a pseudo-random generator whose value drives the output pins directly. Both sequences use an 18-bit linear feedback shift register with taps x^18 + x^11 + 1. The result is read back over the ordinary shift path, because capture does nothing in these two modes.

The mode machine has four states: MODE_SAMPLE (reset state), MODE_EXTEST, MODE_SIG and MODE_PAT. On every `tck` edge it moves to the state that the `mode_code` input named during the previous cycle, so any state can go to any other, including to itself. The shift stage chooses one action per edge: ACT_CAPTURE, ACT_SHIFT, ACT_SIG, ACT_PAT or ACT_HOLD.

Top module: `bsr_scan_ring`

## Requirements
- R1: After reset the mode is sample, both the shift stage and the update stage are zero, `tdo` is 0, `pin_out` equals `core_out` and `core_in` equals `pin_in`.
- R2: The mode takes the value of `mode_code` one `tck` edge after it is presented. The encoding is 00 sample, 01 extest, 10 signature and 11 pattern.
- R3: In sample mode `pin_out` follows `core_out` and `core_in` follows `pin_in`, whatever the strobes do.
- R4: In sample or extest mode, a capture strobe loads `pin_in` into the input half of the shift stage (bits W-1..0) and the present `pin_out` into the output half (bits 2W-1..W).
- R5: Each shift strobe moves the chain one place toward `tdo`. `tdo` shows bit 0, and `tdi` enters at bit 2W-1. The first bits out are the input cells, from pin 0 upward, followed by the output cells from pin 0 upward.
- R6: The update stage loads the whole shift stage on an update strobe and holds its value at all other times.
- R7: In extest and signature modes `pin_out` is the output half of the update stage and `core_in` is its input half.
- R8: In signature mode, each run-idle clock sets the input half to step(input half) XOR `pin_in`, and the output half of the shift stage stays unchanged. Here step(x) = {x[16:0], x[17]^x[10]}. In sample and extest modes a run-idle clock changes nothing.
- R9: In pattern mode, each run-idle clock replaces the output half with step(output half), or with all ones when it is zero. `pin_out` shows the output half of the shift stage, and the input half holds.
- R10: In signature and pattern modes a capture strobe leaves the shift stage unchanged.
- R11: When strobes coincide, capture wins over shift, and shift wins over run-idle, for the shift stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_code | input | 2 | Operating code from the controller |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| run_idle | input | 1 | Run-test/idle strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift-stage bit 0) |
| pin_in | input | W | Input data pins |
| core_in | output | W | Data passed to the transceiver core |
| core_out | input | W | Data the core wants on its outputs |
| pin_out | output | W | Output data pins |

## Verification
The bench sweeps capture and scan-out over many pin words in sample mode and checks that the functional path never glitches. A wrong bit order or an off-by-one in the chain would show up there as scrambled or rotated words. It checks that the one-cycle lag of the mode holds at the switch into extest, and that pins stay put while new data is shifted in without an update. Either would fail if the mode were combinational, or if the update stage leaked the shift stage through. It runs the signature and pattern sequences against an arithmetic model. This includes the zero seed, which a missing lock-up guard would leave stuck at zero. It also includes the capture that comes before readback, which would destroy the signature if capture were not ignored in those modes.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'b00,
        MODE_EXTEST = 2'b01,
        MODE_SIG    = 2'b10,
        MODE_PAT    = 2'b11
    } mode_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CAPTURE,
        ACT_SHIFT,
        ACT_SIG,
        ACT_PAT
    } act_t;

endpackage

// File: rtl/bsr_mode_fsm.sv
module bsr_mode_fsm
    import bsr_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic [1:0] mode_code,
    output mode_t      mode,
    output logic       capt_en,
    output logic       sig_en,
    output logic       pat_en,
    output logic       drive_upd
);

    mode_t mode_q;

    // State register: the next state is whatever the controller names.
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SAMPLE;
        end else begin
            mode_q <= mode_t'(mode_code);
        end
    end

    // Output decode per state.
    always_comb begin
        capt_en   = 1'b0;
        sig_en    = 1'b0;
        pat_en    = 1'b0;
        drive_upd = 1'b0;
        unique case (mode_q)
            MODE_SAMPLE: begin
                capt_en = 1'b1;
            end
            MODE_EXTEST: begin
                capt_en   = 1'b1;
                drive_upd = 1'b1;
            end
            MODE_SIG: begin
                sig_en    = 1'b1;
                drive_upd = 1'b1;
            end
            MODE_PAT: begin
                pat_en = 1'b1;
            end
            default: begin
                capt_en = 1'b1;
            end
        endcase
    end

    assign mode = mode_q;

    // R2: state tracks the previous cycle's code
    p_mode_follows_r2: assert property (@(posedge tck) disable iff (!rst_n)
        $past(rst_n) |-> (mode_q == mode_t'($past(mode_code))));

endmodule

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain
    import bsr_pkg::*;
#(
    parameter int W   = 18,
    parameter int TAP = 11
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           capture,
    input  logic           shift,
    input  logic           run,
    input  logic           capt_en,
    input  logic           sig_en,
    input  logic           pat_en,
    input  logic           tdi,
    input  logic [W-1:0]   snap_in,
    input  logic [W-1:0]   snap_out,
    output logic [2*W-1:0] sr,
    output logic           tdo
);

    localparam int CW = 2 * W;
    localparam int TB = TAP - 1;

    act_t act;

    function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] x);
        return {x[W-2:0], x[W-1] ^ x[TB]};
    endfunction

    // Strobe priority: capture, then shift, then run-idle (R11).
    always_comb begin
        act = ACT_HOLD;
        if (capture) begin
            act = capt_en ? ACT_CAPTURE : ACT_HOLD;
        end else if (shift) begin
            act = ACT_SHIFT;
        end else if (run) begin
            if (sig_en) begin
                act = ACT_SIG;
            end else if (pat_en) begin
                act = ACT_PAT;
            end
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            unique case (act)
                ACT_CAPTURE: sr <= {snap_out, snap_in};
                ACT_SHIFT:   sr <= {tdi, sr[CW-1:1]};
                ACT_SIG:     sr[W-1:0] <= lfsr_next(sr[W-1:0]) ^ snap_in;
                ACT_PAT: begin
                    if (sr[CW-1:W] == '0) begin
                        sr[CW-1:W] <= '1;
                    end else begin
                        sr[CW-1:W] <= lfsr_next(sr[CW-1:W]);
                    end
                end
                default: sr <= sr;
            endcase
        end
    end

    assign tdo = sr[0];

    // R5: the bit presented on tdi lands at the far end of the chain
    p_shift_entry_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (shift && !capture) |=> (sr[CW-1] == $past(tdi)));

    // R10: capture leaves the chain alone in signature and pattern modes
    p_capture_ignored_r10: assert property (@(posedge tck) disable iff (!rst_n)
        (capture && !capt_en) |=> $stable(sr));

    // R8: compression never touches the output half
    p_sig_out_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (run && !capture && !shift && sig_en) |=> $stable(sr[CW-1:W]));

    // R9: the generator never sits in the all-zero state after a step
    p_pat_nonzero_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (run && !capture && !shift && pat_en) |=> (sr[CW-1:W] != '0));

endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage #(
    parameter int N = 36
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R6: holds between update strobes
    p_update_hold_r6: assert property (@(posedge tck) disable iff (!rst_n)
        !load |=> $stable(q));

    // R6: takes the shift stage on an update strobe
    p_update_load_r6: assert property (@(posedge tck) disable iff (!rst_n)
        load |=> (q == $past(d)));

endmodule

// File: rtl/bsr_scan_ring.sv
module bsr_scan_ring
    import bsr_pkg::*;
#(
    parameter int W   = 18,
    parameter int TAP = 11
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic [1:0]   mode_code,
    input  logic         capture_dr,
    input  logic         shift_dr,
    input  logic         update_dr,
    input  logic         run_idle,
    input  logic         tdi,
    output logic         tdo,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] core_in,
    input  logic [W-1:0] core_out,
    output logic [W-1:0] pin_out
);

    localparam int CW = 2 * W;

    mode_t          mode;
    logic           capt_en;
    logic           sig_en;
    logic           pat_en;
    logic           drive_upd;
    logic [CW-1:0]  sr;
    logic [CW-1:0]  upd;

    initial begin
        if (TAP < 2 || TAP >= W) begin
            $error("bsr_scan_ring: TAP must lie in 2..W-1");
        end
    end

    bsr_mode_fsm u_fsm (
        .tck       (tck),
        .rst_n     (rst_n),
        .mode_code (mode_code),
        .mode      (mode),
        .capt_en   (capt_en),
        .sig_en    (sig_en),
        .pat_en    (pat_en),
        .drive_upd (drive_upd)
    );

    bsr_shift_chain #(.W(W), .TAP(TAP)) u_chain (
        .tck      (tck),
        .rst_n    (rst_n),
        .capture  (capture_dr),
        .shift    (shift_dr),
        .run      (run_idle),
        .capt_en  (capt_en),
        .sig_en   (sig_en),
        .pat_en   (pat_en),
        .tdi      (tdi),
        .snap_in  (pin_in),
        .snap_out (pin_out),
        .sr       (sr),
        .tdo      (tdo)
    );

    bsr_update_stage #(.N(CW)) u_upd (
        .tck   (tck),
        .rst_n (rst_n),
        .load  (update_dr),
        .d     (sr),
        .q     (upd)
    );

    // Pin and core steering per mode (R3, R7, R9).
    always_comb begin
        pin_out = core_out;
        core_in = pin_in;
        unique case (mode)
            MODE_SAMPLE: begin
                pin_out = core_out;
                core_in = pin_in;
            end
            MODE_EXTEST, MODE_SIG: begin
                pin_out = upd[CW-1:W];
                core_in = upd[W-1:0];
            end
            MODE_PAT: begin
                pin_out = sr[CW-1:W];
                core_in = upd[W-1:0];
            end
            default: begin
                pin_out = core_out;
                core_in = pin_in;
            end
        endcase
    end

    // R3: a sample code last cycle means the functional path is intact
    p_normal_pass_r3: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode_code) == 2'b00)) |->
            (pin_out == core_out && core_in == pin_in));

    // R7: test modes other than pattern keep the pins off the core
    p_test_isolation_r7: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_code) != 2'b00 && $past(update_dr) == 1'b0
            && $past(mode_code) != 2'b11 && $stable(mode)) |-> $stable(pin_out));

endmodule

// File: tb/bsr_scan_ring_tb.sv
module bsr_scan_ring_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 18;
    localparam int CW = 2 * W;
    localparam logic [W-1:0] ONES = '1;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_code = 2'b00;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic         run_idle = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] core_in;
    logic [W-1:0] core_out = '0;
    logic [W-1:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bsr_scan_ring #(.W(W), .TAP(11)) u_dut (
        .tck        (tck),
        .rst_n      (rst_n),
        .mode_code  (mode_code),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .run_idle   (run_idle),
        .tdi        (tdi),
        .tdo        (tdo),
        .pin_in     (pin_in),
        .core_in    (core_in),
        .core_out   (core_out),
        .pin_out    (pin_out)
    );

    always #(CLK_PERIOD / 2) tck = ~tck;

    task automatic check(input bit ok, input string req,
                         input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    // Arithmetic model of one LFSR step, x^18 + x^11 + 1.
    function automatic logic [W-1:0] step(input logic [W-1:0] x);
        int v;
        int fb;
        v  = int'(x);
        fb = ((v >> 17) ^ (v >> 10)) & 1;
        return W'(((v << 1) & ((1 << W) - 1)) | fb);
    endfunction

    task automatic scan(input logic [CW-1:0] din, output logic [CW-1:0] dout);
        for (int i = 0; i < CW; i++) begin
            tdi      = din[i];
            dout[i]  = tdo;
            shift_dr = 1'b1;
            tick();
        end
        shift_dr = 1'b0;
        tdi      = 1'b0;
    endtask

    task automatic pulse_capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    task automatic pulse_update();
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] got;
        logic [CW-1:0] vec;
        logic [W-1:0]  sig;
        logic [W-1:0]  pat;
        logic [W-1:0]  seed_in;

        tick();
        tick();
        core_out = 18'h2A5C3;
        pin_in   = 18'h15A3C;
        #1;
        // R1: reset state
        check(pin_out == core_out, "R1 pin_out passthrough in reset", CW'(pin_out), CW'(core_out));
        check(core_in == pin_in, "R1 core_in passthrough in reset", CW'(core_in), CW'(pin_in));
        check(tdo == 1'b0, "R1 tdo zero", CW'(tdo), '0);
        rst_n = 1'b1;
        tick();
        scan('0, got);
        check(got == '0, "R1 shift stage zero after reset", got, '0);
        mode_code = 2'b01;
        tick();
        check(pin_out == '0 && core_in == '0, "R1 update stage zero after reset",
              {pin_out, core_in}, '0);
        mode_code = 2'b00;
        tick();

        // R4 R5 R3: sample sweep, capture and scan out many pin words
        for (int k = 0; k < 24; k++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'((k * 48271 + 13) ^ (1 << (k % W)));
            b = W'((k * 69621 + 5) ^ (ONES >> (k % 7)));
            pin_in   = a;
            core_out = b;
            #1;
            pulse_capture();
            vec = {W'(k * 7919), W'(k * 104729)};
            scan(vec, got);
            check(got == {b, a}, "R4 R5 sample capture order", got, {b, a});
            check(pin_out == core_out && core_in == pin_in,
                  "R3 functional path untouched by scan", {pin_out, core_in}, {core_out, pin_in});
        end

        // R3 R6: update in sample mode leaves pins alone
        vec = {18'h3C0F1, 18'h0A5A5};
        scan(vec, got);
        pulse_update();
        check(pin_out == core_out, "R3 update does not reach pins in sample",
              CW'(pin_out), CW'(core_out));

        // R2: mode lags the code by one edge
        mode_code = 2'b01;
        #1;
        check(pin_out == core_out, "R2 mode not yet switched", CW'(pin_out), CW'(core_out));
        tick();
        check(pin_out == vec[CW-1:W] && core_in == vec[W-1:0],
              "R2 R7 extest drives update stage", {pin_out, core_in}, vec);

        // R6: new shift data without update does not reach pins
        scan({18'h00FF0, 18'h12345}, got);
        check(pin_out == vec[CW-1:W] && core_in == vec[W-1:0],
              "R6 update stage holds", {pin_out, core_in}, vec);
        pulse_update();
        vec = {18'h00FF0, 18'h12345};
        check(pin_out == vec[CW-1:W] && core_in == vec[W-1:0],
              "R6 update stage loads", {pin_out, core_in}, vec);

        // R4 R8: extest capture, then run-idle changes nothing
        pin_in = 18'h2B6D9;
        #1;
        pulse_capture();
        run_idle = 1'b1;
        tick();
        tick();
        tick();
        run_idle = 1'b0;
        scan(vec, got);
        check(got == {18'h00FF0, 18'h2B6D9}, "R4 R8 extest capture then idle",
              got, {18'h00FF0, 18'h2B6D9});

        // R11: capture wins over shift
        pin_in = 18'h1F00F;
        capture_dr = 1'b1;
        shift_dr   = 1'b1;
        tick();
        capture_dr = 1'b0;
        shift_dr   = 1'b0;
        check(tdo == 1'b1, "R11 capture beats shift", CW'(tdo), 1);

        // R8 R10: signature compression
        mode_code = 2'b10;
        tick();
        seed_in = 18'h0C3A1;
        scan({18'h2D2D2, seed_in}, got);
        sig = seed_in;
        run_idle = 1'b1;
        for (int i = 0; i < 40; i++) begin
            pin_in = W'(i * 190877 + 7);
            sig = step(sig) ^ pin_in;
            tick();
        end
        run_idle = 1'b0;
        check(pin_out == vec[CW-1:W], "R7 signature mode pins from update stage",
              CW'(pin_out), CW'(vec[CW-1:W]));
        pin_in = 18'h3FFFF;
        #1;
        pulse_capture();
        scan('0, got);
        check(got == {18'h2D2D2, sig}, "R8 R10 signature readback", got, {18'h2D2D2, sig});

        // R9 R10: pattern generator with zero seed
        mode_code = 2'b11;
        tick();
        seed_in = 18'h13579;
        scan({18'h00000, seed_in}, got);
        check(pin_out == '0, "R9 pins show zero seed", CW'(pin_out), '0);
        run_idle = 1'b1;
        tick();
        check(pin_out == ONES, "R9 zero seed becomes all ones", CW'(pin_out), CW'(ONES));
        pat = ONES;
        for (int i = 0; i < 60; i++) begin
            pat = step(pat);
            tick();
            check(pin_out == pat, "R9 pattern step", CW'(pin_out), CW'(pat));
        end
        run_idle = 1'b0;
        pulse_capture();
        scan('0, got);
        check(got == {pat, seed_in}, "R9 R10 pattern readback", got, {pat, seed_in});

        // R9: nonzero seed steps directly
        scan({18'h00001, 18'h0}, got);
        run_idle = 1'b1;
        tick();
        run_idle = 1'b0;
        check(pin_out == step(18'h00001), "R9 nonzero seed", CW'(pin_out), CW'(step(18'h00001)));

        // R3: back to sample
        mode_code = 2'b00;
        tick();
        core_out = 18'h0BEEF;
        #1;
        check(pin_out == core_out && core_in == pin_in, "R3 sample restored",
              {pin_out, core_in}, {core_out, pin_in});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule